// File: doc/BRIEF.md
# Daisy-Chained FIFO Depth Extender

This block joins two to four equal FIFO segments on one clock so that, from the outside, they act as a single FIFO with the combined depth. Each segment has its own small memory, pointers and occupancy count. Two ownership tokens travel around a ring of segments. The write token marks the segment that currently takes new words. The read token marks the segment that currently supplies the oldest word.

A segment hands a token to its ring neighbour when it uses its own top address. Writing that address sends the write token on, and reading it sends the read token on. The handoff is a registered one-cycle pulse. The segment drops the token on the edge that raises the pulse, and the neighbour picks the token up on the following edge. A per-segment strap input selects the segment that holds both tokens after reset. The top ties that strap low on segment 0 only.

The chain-level full and empty outputs come from the segments that hold the tokens. The read port is show-ahead: the oldest word is presented whenever the chain is not empty, and asserting the read strobe consumes it.

Top module: `xchain_top`

## Requirements
- R1: Synchronous active-low reset. Reset leaves `empty` at 1 and `full` at 0, and both `wr_owner` and `rd_owner` equal 1 (bit i set means segment i holds the token).
- R2: A write is accepted on a clock edge only when `wr_en` is 1 and `full` is 0, and it goes only into the write-token holder. A write attempted while `full` is 1 changes neither the stored data nor the token ownership.
- R3: When the holder accepts a write to its top address, `wr_owner` reads 0 for exactly one cycle. After that cycle the next segment in the ring holds the write token, and `full` is 1 during the gap cycle.
- R4: When the holder accepts a read of its top address, `rd_owner` reads 0 for exactly one cycle. After that cycle the next segment holds the read token, and `empty` is 1 during the gap cycle.
- R5: The last segment passes both tokens back to segment 0.
- R6: Words leave the chain in exactly the order they were accepted, across any number of segment boundaries and ring turns.
- R7: `full` is 1 whenever the write-token holder has all of its locations occupied.
- R8: `empty` is 1 whenever the read-token holder has no occupied location. A read attempted while `empty` is 1 consumes nothing.
- R9: A read and a write accepted on the same edge both take effect, including when both target the same segment.
- R10: While `empty` is 0, `rd_data` shows the oldest stored word without waiting for a read strobe.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all segments |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Chain cannot accept a write this cycle |
| rd_en | input | 1 | Read strobe, consumes the word on `rd_data` |
| rd_data | output | DATA_W | Oldest stored word (show-ahead) |
| empty | output | 1 | Chain has no word to deliver this cycle |
| wr_owner | output | SEG_COUNT | One-hot write-token holder, 0 during a handoff |
| rd_owner | output | SEG_COUNT | One-hot read-token holder, 0 during a handoff |

## Verification
Three situations can fall on the same edge. A write token handoff can coincide with a read token handoff. A write and a read can both be accepted by the same segment. A read can empty a segment while a write refills it. The bench provokes all three with random strobes at high write and read rates, including a phase in which both strobes are nearly always set. It judges each cycle against a ring model built from the requirements, which tracks per-segment occupancy, token position and gap cycles. That model predicts `full`, `empty`, both owner vectors and the show-ahead word.

// File: rtl/xchain_pkg.sv
package xchain_pkg;

   // Ring neighbour feeding segment idx, for a ring of n segments
   function automatic int unsigned ring_prev(int unsigned idx, int unsigned n);
      return (idx == 0) ? n - 1 : idx - 1;
   endfunction

   // Power-of-two test used by elaboration checks
   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/xchain_token.sv
module xchain_token (
   input  logic clk,
   input  logic rst_n,
   input  logic first_n,    // strap: low means this segment owns the token after reset
   input  logic pass_in,    // pulse from the previous segment
   input  logic done,       // this segment used its top address on this edge
   output logic own,
   output logic pass_out    // one-cycle pulse to the next segment
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own      <= ~first_n;
         pass_out <= 1'b0;
      end else begin
         pass_out <= own & done;
         if (own & done)
            own <= 1'b0;
         else if (pass_in)
            own <= 1'b1;
      end
   end

   AST_TOKEN_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_in |=> own);                                   // R3
   AST_TOKEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (own && done) |=> (!own && pass_out));              // R4

endmodule

// File: rtl/xchain_seg.sv
module xchain_seg #(
   parameter int unsigned DATA_W = 18,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_n,
   input  logic              wxi,
   input  logic              rxi,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] q,
   output logic              seg_full,
   output logic              seg_empty,
   output logic              wtok,
   output logic              rtok,
   output logic              wxo,
   output logic              rxo
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     waddr, raddr;
   logic [CW-1:0]     cnt;
   logic              wr_do, rd_do;

   assign seg_full  = (cnt == CW'(DEPTH));
   assign seg_empty = (cnt == '0);
   assign wr_do     = wr_en & wtok & ~seg_full;
   assign rd_do     = rd_en & rtok & ~seg_empty;
   assign q         = mem[raddr];

   always_ff @(posedge clk) begin
      if (wr_do)
         mem[waddr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waddr <= '0;
         raddr <= '0;
         cnt   <= '0;
      end else begin
         if (wr_do) waddr <= waddr + 1'b1;
         if (rd_do) raddr <= raddr + 1'b1;
         case ({wr_do, rd_do})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   xchain_token u_wtok (
      .clk(clk), .rst_n(rst_n), .first_n(first_n), .pass_in(wxi),
      .done(wr_do && (waddr == TOP)), .own(wtok), .pass_out(wxo));

   xchain_token u_rtok (
      .clk(clk), .rst_n(rst_n), .first_n(first_n), .pass_in(rxi),
      .done(rd_do && (raddr == TOP)), .own(rtok), .pass_out(rxo));

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));                                 // R7
   AST_NO_TOKEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wtok || !wr_en) |=> $stable(waddr));              // R2
   AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_empty || !rd_en) |=> $stable(raddr));          // R8
   AST_BOTH_KEEP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_do && rd_do) |=> $stable(cnt));                 // R9

endmodule

// File: rtl/xchain_top.sv
module xchain_top #(
   parameter int unsigned DATA_W    = 18,
   parameter int unsigned SEG_DEPTH = 8,
   parameter int unsigned SEG_COUNT = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   output logic                 full,
   input  logic                 rd_en,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 empty,
   output logic [SEG_COUNT-1:0] wr_owner,
   output logic [SEG_COUNT-1:0] rd_owner
);

   if (SEG_COUNT < 2 || SEG_COUNT > 4) begin : g_bad_count
      $error("SEG_COUNT must lie in 2..4");
   end
   if (!xchain_pkg::is_pow2(SEG_DEPTH) || SEG_DEPTH < 2) begin : g_bad_depth
      $error("SEG_DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [SEG_COUNT-1:0] wtok, rtok, sfull, sempty, wxo, rxo;
   logic [DATA_W-1:0]    q_arr [SEG_COUNT];

   for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
      localparam int unsigned PREV = xchain_pkg::ring_prev(g, SEG_COUNT);
      xchain_seg #(.DATA_W(DATA_W), .DEPTH(SEG_DEPTH)) u_seg (
         .clk      (clk),
         .rst_n    (rst_n),
         .first_n  ((g != 0) ? 1'b1 : 1'b0),
         .wxi      (wxo[PREV]),
         .rxi      (rxo[PREV]),
         .wr_en    (wr_en),
         .wr_data  (wr_data),
         .rd_en    (rd_en),
         .q        (q_arr[g]),
         .seg_full (sfull[g]),
         .seg_empty(sempty[g]),
         .wtok     (wtok[g]),
         .rtok     (rtok[g]),
         .wxo      (wxo[g]),
         .rxo      (rxo[g]));
   end

   assign full     = ~|(wtok & ~sfull);
   assign empty    = ~|(rtok & ~sempty);
   assign wr_owner = wtok;
   assign rd_owner = rtok;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < SEG_COUNT; i++)
         if (rtok[i]) rd_data = q_arr[i];
   end

   AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_owner));                                // R3
   AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_owner));                                // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_owner == '0) |-> full);                         // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_owner == '0) |-> empty);                        // R4
   AST_WRAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wxo[SEG_COUNT-1] |=> wr_owner[0]);                  // R5

endmodule

// File: tb/xchain_top_tb_top.sv
module xchain_top_tb_top;

   localparam int W = 18;
   localparam int D = 8;
   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en, rd_en;
   logic [W-1:0] wr_data;
   logic         full, empty;
   logic [W-1:0] rd_data;
   logic [N-1:0] wr_owner, rd_owner;

   always #2 clk = ~clk;

   xchain_top #(.DATA_W(W), .SEG_DEPTH(D), .SEG_COUNT(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
      .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
      .wr_owner(wr_owner), .rd_owner(rd_owner));

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done_flag = 0;

   // reference ring model
   int mcnt [N];
   int mwa [N];
   int mra [N];
   int wseg, rseg;
   bit wgap, rgap;
   logic [W-1:0] mq [$];
   bit wrap_pend, rej_pend, both_pend;

   function automatic bit exp_full();
      return wgap || (mcnt[wseg] == D);
   endfunction
   function automatic bit exp_empty();
      return rgap || (mcnt[rseg] == 0);
   endfunction
   function automatic int exp_owner(bit gap, int seg);
      return gap ? 0 : (1 << seg);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic compare_all();
      check("R7 full", 32'(full), 32'(exp_full()));
      check("R8 empty", 32'(empty), 32'(exp_empty()));
      check("R3 wr_owner", 32'(wr_owner), 32'(exp_owner(wgap, wseg)));
      check("R4 rd_owner", 32'(rd_owner), 32'(exp_owner(rgap, rseg)));
      if (!exp_empty()) check("R6 R10 rd_data", 32'(rd_data), 32'(mq[0]));
      if (wrap_pend) check("R5 wrap", 32'(wr_owner), 32'(1));
      if (rej_pend)  check("R2 rejected write", 32'(wr_owner), 32'(exp_owner(wgap, wseg)));
      if (both_pend && !exp_empty()) check("R9 same-edge", 32'(rd_data), 32'(mq[0]));
      wrap_pend = 0; rej_pend = 0; both_pend = 0;
   endtask

   task automatic step(bit we, bit re);
      bit wacc, racc;
      int ws, rs;
      logic [W-1:0] d;
      compare_all();
      d = W'($urandom);
      wr_en = we; rd_en = re; wr_data = d;
      wacc = we && !exp_full();
      racc = re && !exp_empty();
      ws = wseg; rs = rseg;
      @(posedge clk);
      cyc++;
      rej_pend  = we && !wacc;
      both_pend = wacc && racc;
      if (racc) begin void'(mq.pop_front()); mcnt[rs]--; end
      if (wacc) begin mq.push_back(d); mcnt[ws]++; end
      if (wgap) begin
         wgap = 0;
         if (wseg == N - 1) wrap_pend = 1;
         wseg = (wseg + 1) % N;
      end else if (wacc) begin
         if (mwa[ws] == D - 1) begin mwa[ws] = 0; wgap = 1; end
         else mwa[ws]++;
      end
      if (rgap) begin
         rgap = 0;
         rseg = (rseg + 1) % N;
      end else if (racc) begin
         if (mra[rs] == D - 1) begin mra[rs] = 0; rgap = 1; end
         else mra[rs]++;
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < N; i++) begin mcnt[i] = 0; mwa[i] = 0; mra[i] = 0; end
      wseg = 0; rseg = 0; wgap = 0; rgap = 0;
      wrap_pend = 0; rej_pend = 0; both_pend = 0;
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 empty", 32'(empty), 32'(1));
      check("R1 full", 32'(full), 32'(0));
      check("R1 wr_owner", 32'(wr_owner), 32'(1));
      check("R1 rd_owner", 32'(rd_owner), 32'(1));
      // directed: read while empty, fill past capacity, write while full, drain past empty
      repeat (3) step(1'b0, 1'b1);
      repeat (N * D + 2 * N + 6) step(1'b1, 1'b0);
      repeat (N * D + 2 * N + 6) step(1'b0, 1'b1);
      // directed: both strobes on every edge through several boundaries
      repeat (5) step(1'b1, 1'b0);
      repeat (4 * N * D) step(1'b1, 1'b1);
      // constrained random phases
      for (int ph = 0; ph < 4; ph++) begin
         int pw, pr;
         case (ph)
            0: begin pw = 70; pr = 30; end
            1: begin pw = 30; pr = 70; end
            2: begin pw = 50; pr = 50; end
            default: begin pw = 95; pr = 95; end
         endcase
         repeat (1000) step(($urandom % 100) < pw, ($urandom % 100) < pr);
      end
      repeat (N * D + 2 * N + 6) step(1'b0, 1'b1);
      check("R8 final empty", 32'(empty), 32'(1));
      done_flag = 1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

endmodule